// File: doc/BRIEF.md
# SMBus Alert Response Slave

This block is the slave-side half of the SMBus alert mechanism. When local logic raises an alert request, the block pulls its open-drain alert line low and keeps it low. It then watches the bus, which it samples with the system clock. When a master issues a read to the reserved alert response address, the block acknowledges it and sends its own 7-bit address back on the data line. Its alert stays asserted until it has finished that address.

Several devices may answer the same alert response read. The data line is a wired-AND, so a device that releases the line for a 1 bit and sees the line low has lost to a lower address. It then falls silent for the rest of the byte and keeps its alert asserted for a later round. The block never drives SCL, and it handles no other transfer on the bus.

Top module: `smba_alert_resp`

## Requirements
- R1: After reset, sda_oe, alert_oe and alert_done are all 0.
- R2: A one-cycle pulse on alert_req drives alert_oe to 1 from the next clock edge. It stays 1 until the block wins an alert response round.
- R3: With an alert pending, when the byte after a start is 0x19 (address 0001100 in the upper seven bits and read bit 1 in bit 0, most significant bit first), the block pulls SDA low (sda_oe = 1) for the acknowledge clock that follows.
- R4: A byte other than 0x19, including the write form 0x18, gets no acknowledge. sda_oe stays 0 until the next start or stop, and alert_oe is unchanged.
- R5: With no alert pending, a 0x19 byte gets no acknowledge.
- R6: After acknowledging, the block sends own_addr most significant bit first, one bit per SCL period, with sda_oe = 1 for a 0 bit. It releases SDA (sda_oe = 0) for the eighth bit. SDA changes only while SCL is low.
- R7: If SDA reads low at an SCL rising edge while the block is releasing it during one of the seven address bits, the block has lost. sda_oe stays 0 until the next start or stop, and alert_oe stays 1.
- R8: If the block sends its address without losing, alert_oe goes to 0 and alert_done pulses for one clock at the SCL rising edge of the eighth bit.
- R9: The acknowledge or no-acknowledge that the master sends after the returned byte does not affect the block: sda_oe stays 0.
- R10: A start condition (SDA falling while SCL is high) during a response aborts it. sda_oe returns to 0, alert_oe stays 1, and the byte that follows is decoded as a new address.
- R11: A stop condition (SDA rising while SCL is high) returns the block to idle with sda_oe = 0. A later start is handled normally.
- R12: When two alerting devices answer together, the one with the lower 7-bit address wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level as seen on the bus |
| sda_i | input | 1 | SDA level as seen on the bus |
| own_addr | input | ADDR_W | The device's own 7-bit address, returned in a response |
| alert_req | input | 1 | Pulse that raises an alert |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| alert_oe | output | 1 | 1 pulls the alert line low, 0 releases it |
| alert_done | output | 1 | One-cycle pulse when the alert has been served |

## Verification
The bench builds the block with its default parameters: a 7-bit address, two synchronizer stages and the standard reserved address. An SCL quarter period of five clocks leaves room for the synchronizer delay. Because the address space is only 128 values, the bench can answer an alert round for every own_addr. Each round includes a modelled competing device whose address is computed from the own address, so every bit position where arbitration can be lost is exercised and the winner can be checked against the lower address. The bench also sweeps all 255 other byte values after a start, which covers the write form of the reserved address. Directed sequences cover a repeated start in the middle of a response and a stop in the middle of an address byte.

// File: rtl/smba_pkg.sv
package smba_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACKQ,
    ST_ACK,
    ST_TX,
    ST_HOLD
  } smba_state_e;

endpackage

// File: rtl/smba_sync.sv
// Brings SCL/SDA into the clock domain and flags bus edges and conditions.
module smba_sync #(
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_LEN-1:0] scl_q;
  logic [SYNC_LEN-1:0] sda_q;
  logic                scl_p;
  logic                sda_p;
  logic                scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_LEN-2:0], scl_i};
      sda_q <= {sda_q[SYNC_LEN-2:0], sda_i};
      scl_p <= scl_q[SYNC_LEN-1];
      sda_p <= sda_q[SYNC_LEN-1];
    end
  end

  assign scl_s     = scl_q[SYNC_LEN-1];
  assign sda_s     = sda_q[SYNC_LEN-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smba_rx.sv
// Collects one byte, MSB first, on SCL rising edges.
module smba_rx #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            en,
  input  logic            take,
  input  logic            din,
  output logic [BITS-1:0] byte_q,
  output logic            full
);

  localparam int CW = $clog2(BITS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      byte_q <= '0;
      full   <= 1'b0;
    end else begin
      full <= 1'b0;
      if (clear) begin
        cnt <= '0;
      end else if (en && take) begin
        byte_q <= {byte_q[BITS-2:0], din};
        if (cnt == CW'(BITS - 1)) begin
          cnt  <= '0;
          full <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/smba_ctrl.sv
// Response sequencing: address match, acknowledge, own-address transmit with
// arbitration, alert ownership.
module smba_ctrl
  import smba_pkg::*;
#(
  parameter int                ADDR_W    = 7,
  parameter logic [ADDR_W-1:0] RESP_ADDR = 7'b0001100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic              byte_full,
  input  logic [ADDR_W:0]   rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              alert_req,
  output logic              rx_en,
  output logic              rx_clear,
  output logic              sda_oe,
  output logic              alert_oe,
  output logic              alert_done
);

  localparam logic [ADDR_W:0] MATCH_BYTE = {RESP_ADDR, 1'b1};
  localparam int              CNT_W      = $clog2(ADDR_W + 1);
  localparam logic [CNT_W-1:0] LAST      = CNT_W'(ADDR_W);

  smba_state_e      state;
  logic             pending_q;
  logic             sda_oe_q;
  logic             done_q;
  logic [ADDR_W:0]  tx_sh;
  logic [CNT_W-1:0] tx_cnt;
  logic             win;

  assign win = (state == ST_TX) && scl_rise && !start_det && !stop_det
               && (tx_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pending_q <= 1'b0;
      sda_oe_q  <= 1'b0;
      done_q    <= 1'b0;
      tx_sh     <= '0;
      tx_cnt    <= '0;
    end else begin
      done_q    <= 1'b0;
      pending_q <= (pending_q & ~win) | alert_req;
      if (start_det) begin
        state    <= ST_ADDR;
        sda_oe_q <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (byte_full)
              state <= (rx_byte == MATCH_BYTE && pending_q) ? ST_ACKQ : ST_HOLD;
          end
          ST_ACKQ: begin
            if (scl_fall) begin
              sda_oe_q <= 1'b1;
              state    <= ST_ACK;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              tx_sh    <= {own_addr, 1'b1};
              tx_cnt   <= '0;
              sda_oe_q <= ~own_addr[ADDR_W-1];
              state    <= ST_TX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              if (tx_cnt == LAST) begin
                done_q   <= 1'b1;
                sda_oe_q <= 1'b0;
                state    <= ST_HOLD;
              end else if (!sda_oe_q && !sda_s) begin
                state <= ST_HOLD;
              end else begin
                tx_cnt <= tx_cnt + 1'b1;
              end
            end else if (scl_fall) begin
              tx_sh    <= {tx_sh[ADDR_W-1:0], 1'b0};
              sda_oe_q <= ~tx_sh[ADDR_W-1];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rx_en      = (state == ST_ADDR);
  assign rx_clear   = start_det;
  assign sda_oe     = sda_oe_q;
  assign alert_oe   = pending_q;
  assign alert_done = done_q;

  // R6: the data drive only moves after an SCL fall or a bus condition
  p_sda_on_low_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_q) |-> $past(scl_fall || start_det || stop_det));

  // R5: an acknowledge is only queued while an alert is pending
  p_ack_needs_alert_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACKQ) |-> pending_q);

  // R7: losing leaves the line released and the alert held
  p_loss_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX && scl_rise && !start_det && !stop_det && tx_cnt != LAST
     && !sda_oe_q && !sda_s) |=> (state == ST_HOLD && !sda_oe_q && pending_q));

  // R8: serving the alert releases it, and the served pulse is one cycle
  p_win_clears_alert_r8: assert property (@(posedge clk) disable iff (rst)
    (done_q && !$past(alert_req)) |-> !pending_q);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R10: a start always restarts address reception with the line released
  p_start_aborts_r10: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ADDR && !sda_oe_q));

  // R11: a stop returns to idle
  p_stop_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe_q));

endmodule

// File: rtl/smba_alert_resp.sv
module smba_alert_resp #(
  parameter int                ADDR_W    = 7,
  parameter int                SYNC_LEN  = 2,
  parameter logic [ADDR_W-1:0] RESP_ADDR = 7'b0001100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              alert_req,
  output logic              sda_oe,
  output logic              alert_oe,
  output logic              alert_done
);

  localparam int BYTE_W = ADDR_W + 1;

  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              rx_en;
  logic              rx_clear;
  logic              byte_full;
  logic [BYTE_W-1:0] rx_byte;

  smba_sync #(.SYNC_LEN(SYNC_LEN)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smba_rx #(.BITS(BYTE_W)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .clear  (rx_clear),
    .en     (rx_en),
    .take   (scl_rise),
    .din    (sda_s),
    .byte_q (rx_byte),
    .full   (byte_full)
  );

  smba_ctrl #(.ADDR_W(ADDR_W), .RESP_ADDR(RESP_ADDR)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_s      (sda_s),
    .byte_full  (byte_full),
    .rx_byte    (rx_byte),
    .own_addr   (own_addr),
    .alert_req  (alert_req),
    .rx_en      (rx_en),
    .rx_clear   (rx_clear),
    .sda_oe     (sda_oe),
    .alert_oe   (alert_oe),
    .alert_done (alert_done)
  );

endmodule

// File: tb/sim_smba_alert_resp.sv
module sim_smba_alert_resp;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;
  localparam int AW         = 7;
  localparam int WDOG       = 190000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          scl_drv = 1'b1;
  logic          m_low = 1'b0;
  logic          c_low = 1'b0;
  logic [AW-1:0] own_addr = '0;
  logic          alert_req = 1'b0;
  logic          sda_oe;
  logic          alert_oe;
  logic          alert_done;
  logic          sda_line;

  int tests = 0;
  int fails = 0;
  int done_cnt = 0;
  logic samp;
  logic finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign sda_line = ~(m_low | c_low | sda_oe);

  smba_alert_resp u0 (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_drv),
    .sda_i      (sda_line),
    .own_addr   (own_addr),
    .alert_req  (alert_req),
    .sda_oe     (sda_oe),
    .alert_oe   (alert_oe),
    .alert_done (alert_done)
  );

  always @(posedge clk) if (!rst && alert_done) done_cnt = done_cnt + 1;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  // start or repeated start; leaves SCL low
  task automatic bus_start();
    if (scl_drv == 1'b0) begin
      waitq(1); m_low = 1'b0; c_low = 1'b0;
      waitq(1); scl_drv = 1'b1;
      waitq(1);
    end
    m_low = 1'b1;
    waitq(1); scl_drv = 1'b0;
  endtask

  task automatic bus_stop();
    waitq(1); m_low = 1'b1; c_low = 1'b0;
    waitq(1); scl_drv = 1'b1;
    waitq(1); m_low = 1'b0;
    waitq(2);
  endtask

  // one SCL period; sda_oe sampled in the middle of the high phase
  task automatic bit_clk(input logic m, input logic c);
    waitq(1); m_low = m; c_low = c;
    waitq(1); scl_drv = 1'b1;
    waitq(1); samp = sda_oe;
    waitq(1); scl_drv = 1'b0;
  endtask

  task automatic master_byte(input logic [7:0] b, output logic ack_oe);
    for (int i = 7; i >= 0; i--) bit_clk(~b[i], 1'b0);
    bit_clk(1'b0, 1'b0);
    ack_oe = samp;
  endtask

  task automatic raise_alert();
    @(negedge clk); alert_req = 1'b1;
    @(negedge clk); alert_req = 1'b0;
  endtask

  // response byte with an optional modelled competitor
  task automatic tx_phase(input logic [AW-1:0] own, input logic comp_en,
                          input logic [AW-1:0] comp, output logic won);
    logic dut_on, comp_on, ob, cb, ex, cl, line;
    dut_on  = 1'b1;
    comp_on = comp_en;
    for (int i = AW - 1; i >= 0; i--) begin
      ob = own[i];
      cb = comp[i];
      ex = dut_on & ~ob;
      cl = comp_on & ~cb;
      bit_clk(1'b0, cl);
      if (dut_on) chk($sformatf("R6 addr bit %0d own=%0d", i, own), samp, ex);
      else        chk($sformatf("R7 silent after loss bit %0d own=%0d", i, own), samp, ex);
      line = ~(ex | cl);
      if (dut_on && ob && !line) dut_on = 1'b0;
      if (comp_on && cb && !line) comp_on = 1'b0;
    end
    bit_clk(1'b0, 1'b0);
    chk("R6 eighth bit released", samp, 0);
    won = dut_on;
  endtask

  task automatic ara_round(input logic [AW-1:0] own, input logic comp_en,
                           input logic [AW-1:0] comp);
    logic ack, won;
    int   snap;
    own_addr = own;
    raise_alert();
    snap = done_cnt;
    bus_start();
    master_byte(8'h19, ack);
    chk($sformatf("R3 ack own=%0d", own), ack, 1);
    tx_phase(own, comp_en, comp, won);
    bit_clk(1'b1, 1'b0);
    chk("R9 master ack ignored", samp, 0);
    bus_stop();
    chk($sformatf("R8/R7 alert after round own=%0d", own), alert_oe, won ? 0 : 1);
    chk("R8 served pulse count", done_cnt - snap, won ? 1 : 0);
    if (comp_en) chk($sformatf("R12 lower wins own=%0d comp=%0d", own, comp),
                     won, (own < comp) ? 1 : 0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired: actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic ack, won;
    logic [AW-1:0] cmp;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sda_oe reset", sda_oe, 0);
    chk("R1 alert_oe reset", alert_oe, 0);
    chk("R1 alert_done reset", alert_done, 0);

    // R5: no alert pending, no acknowledge
    waitq(2);
    bus_start();
    master_byte(8'h19, ack);
    chk("R5 no ack without alert", ack, 0);
    bus_stop();

    // R2: alert raised
    raise_alert();
    chk("R2 alert asserted", alert_oe, 1);

    // R4: every other byte is ignored
    for (int b = 0; b < 256; b++) begin
      if (b == 8'h19) continue;
      bus_start();
      master_byte(8'(b), ack);
      chk($sformatf("R4 no ack byte=%0d", b), ack, 0);
      bit_clk(1'b0, 1'b0);
      chk("R4 stays released", samp, 0);
      bus_stop();
      chk("R4 alert unchanged", alert_oe, 1);
    end

    // R11: stop in the middle of an address byte, then a normal round
    bus_start();
    for (int i = 7; i >= 4; i--) bit_clk(~(8'h19 >> i) & 1'b1, 1'b0);
    bus_stop();
    chk("R11 released after stop", sda_oe, 0);
    ara_round(7'h2A, 1'b0, '0);

    // R5 again: alert already served
    bus_start();
    master_byte(8'h19, ack);
    chk("R5 no ack after served", ack, 0);
    bus_stop();

    // R6/R7/R8/R12: every own address against a computed competitor
    for (int a = 0; a < 128; a++) begin
      cmp = 7'((a * 37 + 11) % 128);
      if (cmp == 7'(a)) ara_round(7'(a), 1'b0, '0);
      else              ara_round(7'(a), 1'b1, cmp);
    end
    // clear any alert left by a lost round
    ara_round(7'h05, 1'b0, '0);

    // R10: repeated start in the middle of a response
    own_addr = 7'h7F;
    raise_alert();
    bus_start();
    master_byte(8'h19, ack);
    chk("R10 first ack", ack, 1);
    bit_clk(1'b0, 1'b0);
    bit_clk(1'b0, 1'b0);
    bus_start();
    waitq(1);
    chk("R10 released after restart", sda_oe, 0);
    chk("R10 alert kept after restart", alert_oe, 1);
    master_byte(8'h19, ack);
    chk("R10 ack after restart", ack, 1);
    tx_phase(7'h7F, 1'b0, '0, won);
    chk("R10 round completes", won, 1);
    bit_clk(1'b0, 1'b0);
    bus_stop();
    chk("R10 alert served", alert_oe, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule